// File: doc/BRIEF.md
# Queue Status Flags and Interrupt Request Generator

This block keeps four sticky status flags for a two-queue ADC conversion sequencer. Each queue has one flag for "last command entry finished" and one for "an entry with its pause marker finished". The sequencer raises a one-cycle strobe for each of these events. The flag is set whether or not its interrupt is enabled. A flag drives an interrupt only while its own enable input is high.

Software cannot clear a flag with a single write. It must first read the status word while the flag is one. That read arms the bit. It then writes zero to that bit position. Any new event on the bit between the read and the write disarms it, so an event is never lost. The two sources of a queue are combined into one request. Each queue request is steered onto one line of an 8-bit request bus by a 3-bit level input. When both queues pick the same line, their requests share it.

Top module: `qstat_irq`

## Requirements
- R1: After reset, all four flags and all armed bits are zero, `stat_rdata` reads 0 and `irq` is 0.
- R2: A high `done_ev[q]` at a clock edge sets the queue's completion flag. That flag is `stat_rdata[0]` for queue 1 and `stat_rdata[2]` for queue 2.
- R3: A high `pause_ev[q]` at a clock edge sets the queue's pause flag. That flag is `stat_rdata[1]` for queue 1 and `stat_rdata[3]` for queue 2.
- R4: A flag sets even while its enable is low. A set flag contributes to `irq` only while its `irq_en` bit is one. `irq_en` uses the same bit positions as the status word.
- R5: A clock edge with `stat_rd` high while a flag is one arms that flag. A later `stat_wr` with a zero in that bit position then clears the flag.
- R6: Writing zero to a flag that is not armed leaves the flag unchanged.
- R7: An event on a flag after the arming read and before the clearing write disarms the flag. The write then leaves it set, and a fresh read is needed.
- R8: When an event and a clearing write reach the same bit in the same cycle, the flag stays set and becomes disarmed.
- R9: Writing one to any flag position has no effect on that flag.
- R10: Queue 1 (flag bits 1:0) drives `irq[lvl_q1]` and queue 2 (flag bits 3:2) drives `irq[lvl_q2]`. Each queue drives its line while any of its enabled flags is set. All other lines stay low.
- R11: When `lvl_q1` equals `lvl_q2`, the shared line stays high while either queue requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_ev | input | 2 | Last-entry result strobe, bit 0 queue 1, bit 1 queue 2 |
| pause_ev | input | 2 | Pause-entry result strobe, bit 0 queue 1, bit 1 queue 2 |
| stat_rd | input | 1 | Status read strobe; arms flags that read as one |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 4 | Write data; zero bits request a clear |
| stat_rdata | output | 4 | Current flags {pause q2, done q2, pause q1, done q1} |
| irq_en | input | 4 | Per-flag interrupt enables, same layout as status |
| lvl_q1 | input | 3 | Request line chosen for queue 1 |
| lvl_q2 | input | 3 | Request line chosen for queue 2 |
| irq | output | 8 | Interrupt request lines |

## Verification
A flag stuck low hides a finished queue. It shows at `stat_rdata` one cycle after the strobe, and on `irq` in the same cycle once enabled. A wrong armed bit is hidden until software writes zero. The flag then clears with no arming read, or survives a proper handshake. So the bench probes each arming path with a write at once after a read, after an intervening event and with no read at all. A wrong level decode shows at once as a request on the wrong `irq` line.

// File: rtl/qstat_irq.sv
module qstat_irq #(
  parameter int NQ = 2,
  parameter int LW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     done_ev,
  input  logic [NQ-1:0]     pause_ev,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [2*NQ-1:0]   stat_wdata,
  output logic [2*NQ-1:0]   stat_rdata,
  input  logic [2*NQ-1:0]   irq_en,
  input  logic [LW-1:0]     lvl_q1,
  input  logic [LW-1:0]     lvl_q2,
  output logic [(1<<LW)-1:0] irq
);
  localparam int NF = 2 * NQ;
  localparam int NL = 1 << LW;

  logic [NF-1:0] flag, armed, ev, wclr;
  logic [NQ-1:0] qreq;

  always_comb
    for (int q = 0; q < NQ; q++) begin
      ev[2*q]   = done_ev[q];
      ev[2*q+1] = pause_ev[q];
    end

  assign wclr = {NF{stat_wr}} & ~stat_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag  <= '0;
      armed <= '0;
    end else begin
      flag  <= ev | (flag & ~(wclr & armed));
      armed <= ~ev & ~wclr & (armed | ({NF{stat_rd}} & flag));
    end

  assign stat_rdata = flag;

  always_comb
    for (int q = 0; q < NQ; q++) qreq[q] = |(flag[2*q +: 2] & irq_en[2*q +: 2]);

  assign irq = (NL'(qreq[0]) << lvl_q1) | (NL'(qreq[1]) << lvl_q2);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    |ev |=> ((stat_rdata & $past(ev)) == $past(ev)));  // R2

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag) & ~flag & ~($past(armed) & $past(wclr))) == '0));  // R6

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && &stat_wdata && !stat_rd && ev == '0) |=> $stable(stat_rdata));  // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & irq_en) == '0) |-> (irq == '0));  // R4

  AST_AT_MOST_TWO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq) <= 2);  // R10

  AST_SHARED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q1 == lvl_q2) |-> $onehot0(irq));  // R11
endmodule

// File: tb/test_qstat_irq.sv
module test_qstat_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] done_ev = 0, pause_ev = 0;
  logic stat_rd = 0, stat_wr = 0;
  logic [3:0] stat_wdata = 0, stat_rdata, irq_en = 0;
  logic [2:0] lvl_q1 = 0, lvl_q2 = 0;
  logic [7:0] irq;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qstat_irq i_qstat_irq (.clk(clk), .rst_n(rst_n), .done_ev(done_ev), .pause_ev(pause_ev),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .irq_en(irq_en), .lvl_q1(lvl_q1), .lvl_q2(lvl_q2), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    done_ev = 0; pause_ev = 0; stat_rd = 0; stat_wr = 0; stat_wdata = 0;
  endtask

  task automatic ev(logic [1:0] d, logic [1:0] p);
    done_ev = d; pause_ev = p; step();
  endtask

  task automatic rd();
    stat_rd = 1; step();
  endtask

  task automatic wr(logic [3:0] d);
    stat_wr = 1; stat_wdata = d; step();
  endtask

  task automatic t_reset();
    chk("R1 status", {4'h0, stat_rdata}, 8'h00);
    chk("R1 irq", irq, 8'h00);
  endtask

  task automatic t_set_disabled();
    ev(2'b01, 2'b00);
    chk("R2 done q1", {4'h0, stat_rdata}, 8'h01);
    chk("R4 no irq while disabled", irq, 8'h00);
    ev(2'b00, 2'b10);
    chk("R3 pause q2", {4'h0, stat_rdata}, 8'h09);
  endtask

  task automatic t_enable_levels();
    lvl_q1 = 3; lvl_q2 = 6; irq_en = 4'b0001; #1;
    chk("R4 R10 q1 on line 3", irq, 8'h08);
    irq_en = 4'b1001; #1;
    chk("R10 both queues", irq, 8'h48);
  endtask

  task automatic t_unarmed_and_ones();
    wr(4'h0);
    chk("R6 unarmed write zero", {4'h0, stat_rdata}, 8'h09);
    rd(); wr(4'hF);
    chk("R9 write ones", {4'h0, stat_rdata}, 8'h09);
  endtask

  task automatic t_clear();
    rd(); wr(4'b0110);
    chk("R5 read then write zero", {4'h0, stat_rdata}, 8'h00);
    chk("R5 irq drops", irq, 8'h00);
  endtask

  task automatic t_event_between();
    ev(2'b10, 2'b00);
    rd();
    ev(2'b10, 2'b00);
    wr(4'h0);
    chk("R7 event between read and write", {4'h0, stat_rdata}, 8'h04);
    rd(); wr(4'h0);
    chk("R7 fresh read clears", {4'h0, stat_rdata}, 8'h00);
  endtask

  task automatic t_same_cycle();
    ev(2'b00, 2'b01);
    rd();
    pause_ev = 2'b01; stat_wr = 1; stat_wdata = 4'h0; step();
    chk("R8 set wins over clear", {4'h0, stat_rdata}, 8'h02);
    wr(4'h0);
    chk("R8 disarmed after collision", {4'h0, stat_rdata}, 8'h02);
    rd(); wr(4'h0);
    chk("R5 clear after rearm", {4'h0, stat_rdata}, 8'h00);
  endtask

  task automatic t_shared_level();
    irq_en = 4'hF; lvl_q1 = 5; lvl_q2 = 5;
    ev(2'b11, 2'b00);
    chk("R11 shared line", irq, 8'h20);
    rd(); wr(4'b1110);
    chk("R11 q2 alone holds line", irq, 8'h20);
    lvl_q2 = 0; #1;
    chk("R10 q2 moved to line 0", irq, 8'h01);
    rd(); wr(4'h0);
    chk("R5 all clear", irq, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_set_disabled();
    t_enable_levels();
    t_unarmed_and_ones();
    t_clear();
    t_event_between();
    t_same_cycle();
    t_shared_level();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule